// File: doc/BRIEF.md
# Lane Code-Group Synchronization Monitor

This block sits on the receive side of an 8b/10b gigabit Ethernet lane, after the word aligner and the code-group decoder. Each cycle with `symValid` high carries one decoded code group: the byte, a control flag, a code-error flag from the decoder, and a flag from the aligner that says whether a comma was found on the current word boundary. From this stream the block decides whether the lane holds code-group synchronization. It raises `syncStatus` when it has it, and downstream rate-matching logic waits on that signal.

Acquisition starts at an aligned K28.5. The block then counts synchronization ordered sets. Each set is one K28.5 followed by an odd number of valid data groups, and a set counts as complete when the next aligned K28.5 arrives. Once locked, the block counts bad code groups and drops lock at a set limit. A fixed run of good code groups in a row takes one error off the count. Two debug outputs show the current phase and the number of errors still outstanding. Word alignment, decoding and disparity checking happen upstream.

Top module: `lane_code_sync`

## Requirements
- R1: After reset, `syncStatus` is 0, `dbgPhase` is 0 (loss of sync) and `dbgErrCount` is 0.
- R2: In loss of sync, only an aligned K28.5 has an effect. A K28.5 is a group with the control flag set, byte 0xBC and the code-error flag clear; it is aligned when `symCommaAligned` is 1. Such a group moves `dbgPhase` to 1 (acquisition). Data, other control groups, errored groups and misaligned K28.5 groups leave the block in loss of sync.
- R3: A cycle with `symValid` low changes no output and no internal count.
- R4: In acquisition, a data group is one with the control flag and the code-error flag both clear, and each one toggles the data-count parity. An aligned K28.5 that arrives after an odd number of data groups completes a set. When the third set completes, `syncStatus` goes to 1 and `dbgPhase` to 2 at the edge that takes that K28.5, so lock takes four aligned commas.
- R5: In acquisition, any of the following returns the block to phase 0 and clears its counts: a code error, a misaligned K28.5, a control group other than K28.5, or an aligned K28.5 after an even number of data groups (zero included).
- R6: While locked, a bad group raises `dbgErrCount` by one. A bad group is one with a code error, or a K28.5 with `symCommaAligned` low. The bad group that would make the count four drops lock instead: `syncStatus` 0, `dbgPhase` 0, `dbgErrCount` 0.
- R7: While locked with `dbgErrCount` above 0, four good groups in a row lower the count by one. A bad group restarts the good-run count from zero.
- R8: While locked with `dbgErrCount` at 0, good groups have no effect. Good groups include control groups other than K28.5 and aligned K28.5 groups at any data-count parity.
- R9: `dbgPhase` encodes 0 = loss of sync, 1 = acquisition, 2 = locked. `syncStatus` is 1 exactly when `dbgPhase` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rstN | input | 1 | Asynchronous active-low reset |
| symValid | input | 1 | A decoded code group is present this cycle |
| symData | input | 8 | Decoded byte |
| symIsCtrl | input | 1 | Group is a control (K) code |
| symCodeErr | input | 1 | Decoder flagged the group as invalid |
| symCommaAligned | input | 1 | Comma found on the current word boundary |
| syncStatus | output | 1 | Lane holds code-group synchronization |
| dbgPhase | output | 2 | Current phase (0 loss, 1 acquiring, 2 locked) |
| dbgErrCount | output | $clog2(ERRS_TO_DROP) | Errors outstanding while locked |

## Verification
The bench builds the block with its default parameters: three sets to lock, four errors to drop lock, and four good groups to forgive one error. These small values let short directed sequences reach every limit. That includes the last set before lock, the error just below the drop limit, a good run cut off one group short by an error, and a full forgiveness step. A long random stream, weighted toward commas and data, then keeps crossing between acquisition, lock and loss while a behavioural model is compared against the outputs every cycle.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  typedef enum logic [1:0] {
    PH_LOSS = 2'd0,
    PH_ACQ  = 2'd1,
    PH_SYNC = 2'd2
  } phase_e;

  localparam logic [7:0] COMMA_BYTE = 8'hBC;

  // strobes from control to datapath
  typedef struct packed {
    logic startAcq;
    logic toggleParity;
    logic nextSet;
    logic enterSync;
    logic addErr;
    logic addGood;
    logic clearAll;
  } dpStrobe_t;

  // classification and counter status from datapath to control
  typedef struct packed {
    logic isComma;
    logic isData;
    logic isBad;
    logic isOtherCtrl;
    logic parityOdd;
    logic lastSet;
    logic errAtLimit;
    logic errZero;
  } dpStatus_t;

endpackage

// File: rtl/lsync_datapath.sv
module lsync_datapath
  import lsync_pkg::*;
#(
  parameter int SETS_TO_LOCK    = 3,
  parameter int ERRS_TO_DROP    = 4,
  parameter int GOOD_TO_FORGIVE = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [7:0]                       symData,
  input  logic                             symIsCtrl,
  input  logic                             symCodeErr,
  input  logic                             symCommaAligned,
  input  dpStrobe_t                        strobe,
  output dpStatus_t                        status,
  output logic [$clog2(ERRS_TO_DROP)-1:0]  errCount
);

  localparam int SET_W  = (SETS_TO_LOCK > 2)    ? $clog2(SETS_TO_LOCK)    : 1;
  localparam int ERR_W  = $clog2(ERRS_TO_DROP);
  localparam int GOOD_W = (GOOD_TO_FORGIVE > 2) ? $clog2(GOOD_TO_FORGIVE) : 1;
  localparam logic [SET_W-1:0]  SET_LAST  = SET_W'(SETS_TO_LOCK - 1);
  localparam logic [ERR_W-1:0]  ERR_LAST  = ERR_W'(ERRS_TO_DROP - 1);
  localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(GOOD_TO_FORGIVE - 1);

  logic              parity;
  logic [SET_W-1:0]  setCnt;
  logic [ERR_W-1:0]  errCnt;
  logic [GOOD_W-1:0] goodRun;
  logic              isK;

  // symbol classification
  always_comb begin
    isK                = symIsCtrl && (symData == COMMA_BYTE) && !symCodeErr;
    status.isComma     = isK && symCommaAligned;
    status.isBad       = symCodeErr || (isK && !symCommaAligned);
    status.isData      = !symIsCtrl && !symCodeErr;
    status.isOtherCtrl = symIsCtrl && !symCodeErr && !isK;
    status.parityOdd   = parity;
    status.lastSet     = (setCnt == SET_LAST);
    status.errAtLimit  = (errCnt == ERR_LAST);
    status.errZero     = (errCnt == '0);
  end

  // acquisition counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parity <= 1'b0;
      setCnt <= '0;
    end else if (strobe.clearAll || strobe.startAcq || strobe.enterSync) begin
      parity <= 1'b0;
      setCnt <= '0;
    end else if (strobe.nextSet) begin
      parity <= 1'b0;
      setCnt <= setCnt + 1'b1;
    end else if (strobe.toggleParity) begin
      parity <= ~parity;
    end
  end

  // error and good-run counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCnt  <= '0;
      goodRun <= '0;
    end else if (strobe.clearAll || strobe.enterSync) begin
      errCnt  <= '0;
      goodRun <= '0;
    end else if (strobe.addErr) begin
      errCnt  <= errCnt + 1'b1;
      goodRun <= '0;
    end else if (strobe.addGood && (errCnt != '0)) begin
      if (goodRun == GOOD_LAST) begin
        errCnt  <= errCnt - 1'b1;
        goodRun <= '0;
      end else begin
        goodRun <= goodRun + 1'b1;
      end
    end
  end

  assign errCount = errCnt;

  // R7
  forgive_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (($past(errCnt) > errCnt) && !$past(strobe.clearAll))
      |-> (($past(goodRun) == GOOD_LAST) && (errCnt == $past(errCnt) - 1'b1)));

  // R8
  zero_count_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCnt == '0) |-> (goodRun == '0));

  // R3
  idle_counts_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0) |=> ($stable(errCnt) && $stable(setCnt) && $stable(parity)));

endmodule

// File: rtl/lsync_control.sv
module lsync_control
  import lsync_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      symValid,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output phase_e    phase
);

  phase_e nextPhase;

  always_comb begin
    nextPhase = phase;
    strobe    = '0;
    if (symValid) begin
      unique case (phase)
        PH_LOSS: begin
          if (status.isComma) begin
            strobe.startAcq = 1'b1;
            nextPhase       = PH_ACQ;
          end
        end
        PH_ACQ: begin
          if (status.isData) begin
            strobe.toggleParity = 1'b1;
          end else if (status.isComma && status.parityOdd) begin
            if (status.lastSet) begin
              strobe.enterSync = 1'b1;
              nextPhase        = PH_SYNC;
            end else begin
              strobe.nextSet = 1'b1;
            end
          end else begin
            strobe.clearAll = 1'b1;
            nextPhase       = PH_LOSS;
          end
        end
        PH_SYNC: begin
          if (status.isBad) begin
            if (status.errAtLimit) begin
              strobe.clearAll = 1'b1;
              nextPhase       = PH_LOSS;
            end else begin
              strobe.addErr = 1'b1;
            end
          end else begin
            strobe.addGood = 1'b1;
          end
        end
        default: begin
          strobe.clearAll = 1'b1;
          nextPhase       = PH_LOSS;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_LOSS;
    else       phase <= nextPhase;
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !symValid |=> $stable(phase));

  // R2
  loss_ignores_noncomma_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LOSS && symValid && !status.isComma) |=> (phase == PH_LOSS));

  // R4
  sync_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SYNC && $past(phase) != PH_SYNC)
      |-> $past(status.isComma && status.parityOdd && status.lastSet && symValid));

  // R6
  loss_on_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SYNC && symValid && status.isBad && status.errAtLimit) |=> (phase == PH_LOSS));

  // R5
  acq_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ACQ && symValid && (status.isBad || status.isOtherCtrl)) |=> (phase == PH_LOSS));

endmodule

// File: rtl/lane_code_sync.sv
module lane_code_sync
  import lsync_pkg::*;
#(
  parameter int SETS_TO_LOCK    = 3,
  parameter int ERRS_TO_DROP    = 4,
  parameter int GOOD_TO_FORGIVE = 4
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             symValid,
  input  logic [7:0]                       symData,
  input  logic                             symIsCtrl,
  input  logic                             symCodeErr,
  input  logic                             symCommaAligned,
  output logic                             syncStatus,
  output logic [1:0]                       dbgPhase,
  output logic [$clog2(ERRS_TO_DROP)-1:0]  dbgErrCount
);

  dpStrobe_t strobe;
  dpStatus_t status;
  phase_e    phase;

  lsync_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .symValid (symValid),
    .status   (status),
    .strobe   (strobe),
    .phase    (phase)
  );

  lsync_datapath #(
    .SETS_TO_LOCK    (SETS_TO_LOCK),
    .ERRS_TO_DROP    (ERRS_TO_DROP),
    .GOOD_TO_FORGIVE (GOOD_TO_FORGIVE)
  ) u_datapath (
    .clk             (clk),
    .rstN            (rstN),
    .symData         (symData),
    .symIsCtrl       (symIsCtrl),
    .symCodeErr      (symCodeErr),
    .symCommaAligned (symCommaAligned),
    .strobe          (strobe),
    .status          (status),
    .errCount        (dbgErrCount)
  );

  assign syncStatus = (phase == PH_SYNC);
  assign dbgPhase   = phase;

  // R9
  status_matches_phase_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncStatus |-> (dbgPhase == 2'd2));

  // R6
  count_zero_outside_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncStatus |-> (dbgErrCount == '0));

endmodule

// File: tb/lane_code_sync_test.sv
module lane_code_sync_test;

  localparam int SETS  = 3;
  localparam int ERRS  = 4;
  localparam int GOODN = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       inCtrl = 1'b0;
  logic       inErr = 1'b0;
  logic       inAligned = 1'b0;
  logic       syncStatus;
  logic [1:0] dbgPhase;
  logic [1:0] dbgErrCount;

  int checks = 0;
  int fails = 0;
  string lastReq = "R1";

  int mPhase = 0, mSets = 0, mPar = 0, mErr = 0, mGood = 0;

  always #4 clk = ~clk;

  lane_code_sync #(
    .SETS_TO_LOCK    (SETS),
    .ERRS_TO_DROP    (ERRS),
    .GOOD_TO_FORGIVE (GOODN)
  ) uut (
    .clk             (clk),
    .rstN            (rstN),
    .symValid        (inValid),
    .symData         (inData),
    .symIsCtrl       (inCtrl),
    .symCodeErr      (inErr),
    .symCommaAligned (inAligned),
    .syncStatus      (syncStatus),
    .dbgPhase        (dbgPhase),
    .dbgErrCount     (dbgErrCount)
  );

  // behavioural reference
  always @(posedge clk) begin
    bit kk, comma, bad, data;
    if (!rstN) begin
      mPhase = 0; mSets = 0; mPar = 0; mErr = 0; mGood = 0;
    end else if (inValid) begin
      kk    = inCtrl && (inData == 8'hBC) && !inErr;
      comma = kk && inAligned;
      bad   = inErr || (kk && !inAligned);
      data  = !inCtrl && !inErr;
      if (mPhase == 0) begin
        if (comma) begin mPhase = 1; mSets = 0; mPar = 0; end
      end else if (mPhase == 1) begin
        if (data) mPar = 1 - mPar;
        else if (comma && mPar == 1) begin
          if (mSets == SETS - 1) begin
            mPhase = 2; mSets = 0; mPar = 0; mErr = 0; mGood = 0;
          end else begin
            mSets++; mPar = 0;
          end
        end else begin
          mPhase = 0; mSets = 0; mPar = 0; mErr = 0; mGood = 0;
        end
      end else begin
        if (bad) begin
          if (mErr == ERRS - 1) begin
            mPhase = 0; mSets = 0; mPar = 0; mErr = 0; mGood = 0;
          end else begin
            mErr++; mGood = 0;
          end
        end else if (mErr > 0) begin
          if (mGood == GOODN - 1) begin mErr--; mGood = 0; end
          else mGood++;
        end
      end
    end
  end

  task automatic expectEq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareModel();
    expectEq(lastReq, "model phase", int'(dbgPhase), mPhase);
    expectEq(lastReq, "model sync", int'(syncStatus), (mPhase == 2) ? 1 : 0);
    expectEq(lastReq, "model errcount", int'(dbgErrCount), mErr);
  endtask

  // compare the previous symbol's effect, then drive the next symbol
  task automatic step(input logic v, input logic [7:0] d, input logic c,
                      input logic e, input logic a, input string req);
    @(negedge clk);
    compareModel();
    inValid = v; inData = d; inCtrl = c; inErr = e; inAligned = a;
    lastReq = req;
  endtask

  task automatic settle();
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, lastReq);
    @(negedge clk);
  endtask

  task automatic sendK(input string req);     step(1, 8'hBC, 1, 0, 1, req); endtask
  task automatic sendKMis(input string req);  step(1, 8'hBC, 1, 0, 0, req); endtask
  task automatic sendD(input string req);     step(1, 8'h50, 0, 0, 0, req); endtask
  task automatic sendErr(input string req);   step(1, 8'h00, 0, 1, 0, req); endtask
  task automatic sendCtl(input string req);   step(1, 8'hFB, 1, 0, 0, req); endtask

  task automatic acquire(input string req);
    sendK(req); sendD(req);
    sendK(req); sendD(req); sendD(req); sendD(req);
    sendK(req); sendD(req);
    sendK(req);
    settle();
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    expectEq("R1", "sync in reset", int'(syncStatus), 0);
    expectEq("R1", "phase in reset", int'(dbgPhase), 0);
    expectEq("R1", "errcount in reset", int'(dbgErrCount), 0);
    rstN = 1'b1;

    // R2 loss of sync ignores everything but an aligned comma
    sendD("R2"); sendErr("R2"); sendCtl("R2"); sendKMis("R2");
    step(1, 8'hBC, 1, 1, 1, "R2");
    settle();
    expectEq("R2", "phase after non-commas", int'(dbgPhase), 0);
    sendK("R2"); settle();
    expectEq("R2", "phase after aligned comma", int'(dbgPhase), 1);

    // R3 idle cycles hold acquisition progress
    sendD("R3");
    step(0, 8'hBC, 1, 0, 1, "R3");
    step(0, 8'h00, 0, 1, 0, "R3");
    sendK("R3"); sendD("R3"); sendK("R3"); sendD("R3");
    settle();
    expectEq("R3", "phase after idle gaps", int'(dbgPhase), 1);
    sendK("R3"); settle();
    expectEq("R3", "lock reached across idle gaps", int'(syncStatus), 1);

    // R5 acquisition aborts
    sendErr("R5"); sendErr("R5"); sendErr("R5"); sendErr("R5"); settle();
    expectEq("R5", "dropped before abort tests", int'(dbgPhase), 0);
    sendK("R5"); sendD("R5"); sendD("R5"); sendK("R5"); settle();
    expectEq("R5", "even count comma", int'(dbgPhase), 0);
    sendK("R5"); sendK("R5"); settle();
    expectEq("R5", "zero count comma", int'(dbgPhase), 0);
    sendK("R5"); sendD("R5"); sendErr("R5"); settle();
    expectEq("R5", "code error", int'(dbgPhase), 0);
    sendK("R5"); sendD("R5"); sendCtl("R5"); settle();
    expectEq("R5", "other control", int'(dbgPhase), 0);
    sendK("R5"); sendD("R5"); sendKMis("R5"); settle();
    expectEq("R5", "misaligned comma", int'(dbgPhase), 0);

    // R4 lock after the third completed set, not before
    sendK("R4"); sendD("R4"); sendK("R4"); sendD("R4"); sendD("R4"); sendD("R4");
    sendK("R4"); sendD("R4"); settle();
    expectEq("R4", "not locked before fourth comma", int'(syncStatus), 0);
    sendK("R4"); settle();
    expectEq("R4", "locked on fourth comma", int'(syncStatus), 1);
    expectEq("R9", "locked phase code", int'(dbgPhase), 2);

    // R8 good groups at zero count
    sendD("R8"); sendCtl("R8"); sendK("R8"); sendK("R8"); sendD("R8"); sendCtl("R8");
    settle();
    expectEq("R8", "count at zero", int'(dbgErrCount), 0);
    expectEq("R8", "still locked", int'(syncStatus), 1);

    // R7 forgiveness and run restart
    sendErr("R7"); settle();
    expectEq("R6", "one error", int'(dbgErrCount), 1);
    sendD("R7"); sendD("R7"); sendD("R7"); sendKMis("R7"); settle();
    expectEq("R7", "run cut short", int'(dbgErrCount), 2);
    sendD("R7"); sendD("R7"); sendD("R7"); settle();
    expectEq("R7", "three goods not enough", int'(dbgErrCount), 2);
    sendCtl("R7"); settle();
    expectEq("R7", "fourth good forgives", int'(dbgErrCount), 1);

    // R6 drop at the limit
    sendErr("R6"); sendErr("R6"); settle();
    expectEq("R6", "three outstanding", int'(dbgErrCount), 3);
    expectEq("R6", "still locked at three", int'(syncStatus), 1);
    sendErr("R6"); settle();
    expectEq("R6", "lock dropped", int'(syncStatus), 0);
    expectEq("R6", "count cleared", int'(dbgErrCount), 0);
    expectEq("R9", "loss phase code", int'(dbgPhase), 0);

    acquire("R4");
    expectEq("R4", "relock", int'(syncStatus), 1);

    // random stream against the model
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 38)      sendK("R4");
      else if (r < 80) sendD("R7");
      else if (r < 86) sendErr("R6");
      else if (r < 90) sendKMis("R6");
      else if (r < 94) sendCtl("R8");
      else             step(0, 8'hBC, 1, 0, 1, "R3");
    end
    settle();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule